// File: doc/BRIEF.md
# Interval Timer with Match Interrupt

The block is a small periodic timer for a microcontroller-class subsystem. An up counter advances on a selectable time base and is compared against a software-written reference value. When the two are equal on an advancing tick, the counter returns to zero, a pending flag latches, and a dedicated output pin changes state. The counter then starts the next interval on its own, so the interval is one more tick than the reference value.

Software reaches the timer through a simple synchronous register port with three locations: control, reference and count. A write-one bit in the control register restarts the count and the prescaler at any time. The interrupt request output is raised while the pending flag and the enable bit are both set. Software acknowledges the request by writing zero to the pending bit.

Top module: `itmr_top`

## Requirements
- R1: After a synchronous active-low reset, the control, reference and count registers read 0, and `irq_o` and `match_o` are 0.
- R2: When the counter advances on a tick while its value equals the reference, it becomes 0 at that edge instead of incrementing. The counter is read at address 2, is read-only, and wraps from all-ones to 0.
- R3: Control bits 7:6 pick the time base. Code 2'b11 advances the counter on every clock. Code 2'b00 advances it once every 256 clocks, on the 256th edge after reset or after a restart.
- R4: Control codes 2'b01 and 2'b10 in bits 7:6 hold the counter at its value.
- R5: A control write with bit 3 set zeroes the counter and the prescaler at that edge. A match that falls on the same edge is suppressed. Writing 0 to bit 3 changes nothing, and bit 3 always reads 0.
- R6: Control bit 0 is the pending flag. It becomes 1 on every match, whether or not the interrupt is enabled.
- R7: A control write with bit 0 at 0 clears the pending flag. A write with bit 0 at 1 leaves the flag unchanged. A match on the same edge wins and leaves the flag set.
- R8: `irq_o` is 1 exactly when the pending flag and the enable bit (control bit 1) are both 1.
- R9: `match_o` inverts on every match and holds otherwise.
- R10: The reference register at address 1 can be written while the counter runs, and the new value is used from the next compare on. Writes to address 2 or 3 have no effect, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 reference, 2 count |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |
| match_o | output | 1 | Toggle output, inverted on every match |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are stable around each rising edge and hold only known values once reset is released. They also assume that a restart is the only bus action that may coincide with a match. The stimulus drives every input on the falling edge, keeps reference values small so that matches happen often, and leaves the write strobe low between accesses. Random control writes cover all four time-base codes. Directed sequences place a restart exactly on a match and write to the pending bit while a match is due.

// File: rtl/itmr_pkg.sv
// Package: shared encodings for the interval timer.
// Assumes an 8-bit control layout; the data bus is at least 8 bits wide.
package itmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_REF  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

    localparam int BIT_PEND   = 0;
    localparam int BIT_IEN    = 1;
    localparam int BIT_CLR    = 3;
    localparam int BIT_SEL_LO = 6;
    localparam int BIT_SEL_HI = 7;

    typedef enum logic [1:0] {
        SEL_DIV    = 2'b00,
        SEL_HOLD_A = 2'b01,
        SEL_HOLD_B = 2'b10,
        SEL_FAST   = 2'b11
    } tbase_e;
endpackage

// File: rtl/itmr_prescaler.sv
// Module: time-base generator. A free-running divider yields a one-cycle tick
// every 2**DIV_LOG2 clocks; the select code picks divided, undivided or no tick.
// Assumes restart is a one-cycle strobe that realigns the divider to zero.
module itmr_prescaler
    import itmr_pkg::*;
#(
    parameter int DIV_LOG2 = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  tbase_e sel,
    output logic   tick
);
    localparam int DW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;

    logic [DW-1:0] div_q;
    logic          div_wrap;

    // divider: counts every clock, zeroed by reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    generate
        if (DIV_LOG2 < 1) begin : g_nodiv
            assign div_wrap = 1'b1;
        end else begin : g_div
            assign div_wrap = &div_q;
        end
    endgenerate

    // tick selection by time-base code
    always_comb begin
        unique case (sel)
            SEL_DIV:  tick = div_wrap;
            SEL_FAST: tick = 1'b1;
            default:  tick = 1'b0;
        endcase
    end

    // R3: the divided tick cannot repeat on consecutive cycles
    a_r3_div_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DIV && tick && !restart && DIV_LOG2 > 0) |=> !(tick && sel == SEL_DIV));
endmodule

// File: rtl/itmr_core.sv
// Module: counter, compare and toggle output. On a tick the counter either
// increments or, when equal to the reference, returns to zero and flags a match.
// Assumes restart has priority over both tick and match.
module itmr_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    output logic             match,
    output logic [CNT_W-1:0] count,
    output logic             match_pin
);
    logic [CNT_W-1:0] cnt_q;
    logic             pin_q;

    // compare: valid only on an advancing tick without restart
    always_comb begin
        match = tick && !restart && (cnt_q == ref_val);
    end

    // counter: restart, auto-clear on match, or increment on tick
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (match)        cnt_q <= '0;
        else if (tick)         cnt_q <= cnt_q + 1'b1;
    end

    // toggle output: inverts on each match
    always_ff @(posedge clk) begin
        if (!rst_n)     pin_q <= 1'b0;
        else if (match) pin_q <= ~pin_q;
    end

    assign count     = cnt_q;
    assign match_pin = pin_q;

    // R2: a match leaves the counter at zero
    a_r2_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (count == '0));
    // R5: a restart leaves the counter at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
    // R4: without tick or restart the counter holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
    // R9: the output pin inverts after every match
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (match_pin != $past(match_pin)));
endmodule

// File: rtl/itmr_regs.sv
// Module: register port. Holds control and reference registers and the
// pending flag, decodes the restart strobe and muxes read data.
// Assumes writes are single-cycle strobes; a match outranks a pending clear.
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata,
    output tbase_e            sel,
    output logic [DATA_W-1:0] ref_val,
    output logic              restart,
    output logic              pending,
    output logic              irq
);
    logic              wr_ctrl;
    logic              wr_ref;
    tbase_e            sel_q;
    logic              ien_q;
    logic              pend_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] ctrl_rd;
    logic              unused_wbits;

    assign wr_ctrl      = wr_en && (addr == ADDR_CTRL);
    assign wr_ref       = wr_en && (addr == ADDR_REF);
    assign restart      = wr_ctrl && wdata[BIT_CLR];
    assign unused_wbits = ^wdata;

    // control fields: time base and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_DIV;
            ien_q <= 1'b0;
        end else if (wr_ctrl) begin
            sel_q <= tbase_e'(wdata[BIT_SEL_HI:BIT_SEL_LO]);
            ien_q <= wdata[BIT_IEN];
        end
    end

    // pending flag: set by match, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)                               pend_q <= 1'b0;
        else if (match_i)                         pend_q <= 1'b1;
        else if (wr_ctrl && !wdata[BIT_PEND])     pend_q <= 1'b0;
    end

    // reference register
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '0;
        else if (wr_ref) ref_q <= wdata;
    end

    // control read image; restart bit reads zero
    always_comb begin
        ctrl_rd                         = '0;
        ctrl_rd[BIT_SEL_HI:BIT_SEL_LO]  = sel_q;
        ctrl_rd[BIT_IEN]                = ien_q;
        ctrl_rd[BIT_PEND]               = pend_q;
    end

    // read mux
    always_comb begin
        unique case (addr)
            ADDR_CTRL: rdata = ctrl_rd;
            ADDR_REF:  rdata = ref_q;
            ADDR_CNT:  rdata = count_i;
            default:   rdata = '0;
        endcase
    end

    assign sel     = sel_q;
    assign ref_val = ref_q;
    assign pending = pend_q;
    assign irq     = pend_q & ien_q;

    // R6: a match always leaves the flag set
    a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> pending);
    // R7: writing one to a clear flag does not set it
    a_r7_one_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[BIT_PEND] && !pending && !match_i) |=> !pending);
    // R8: a request never rises without a pending flag
    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> pending);
endmodule

// File: rtl/itmr_top.sv
// Module: interval timer top. Connects the register port, prescaler and
// counter/compare core. Assumes DATA_W >= 8 so the control layout fits.
module itmr_top
    import itmr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              match_o
);
    tbase_e            sel;
    logic              tick;
    logic              restart;
    logic              match;
    logic              pending;
    logic [DATA_W-1:0] ref_val;
    logic [DATA_W-1:0] count;

    itmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .match_i(match), .count_i(count), .rdata(rdata), .sel(sel),
        .ref_val(ref_val), .restart(restart), .pending(pending), .irq(irq_o)
    );

    itmr_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sel(sel), .tick(tick)
    );

    itmr_core #(.CNT_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .ref_val(ref_val), .match(match), .count(count), .match_pin(match_o)
    );
endmodule

// File: tb/test_itmr_top.sv
`timescale 1ns/100ps
module test_itmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_o;
    logic       match_o;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    logic [7:0] m_div, m_cnt, m_ref;
    logic [1:0] m_sel;
    logic       m_en, m_pend, m_tog;

    always #2.5 clk = ~clk;

    itmr_top i_itmr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .match_o(match_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ctrl_img();
        return {m_sel, 4'b0000, m_en, m_pend};
    endfunction

    task automatic model_reset();
        m_div = 0; m_cnt = 0; m_ref = 0; m_sel = 2'b00;
        m_en = 0; m_pend = 0; m_tog = 0;
    endtask

    // model: one clock edge with the given bus access
    task automatic model_edge(input logic w, input logic [1:0] a, input logic [7:0] d);
        logic clr, tk, mt;
        clr = w && a == 2'd0 && d[3];
        tk  = (m_sel == 2'b11) || (m_sel == 2'b00 && m_div == 8'hFF);
        mt  = !clr && tk && (m_cnt == m_ref);
        m_div = clr ? 8'd0 : m_div + 8'd1;
        if (clr || mt) m_cnt = 0;
        else if (tk)   m_cnt = m_cnt + 8'd1;
        if (mt) m_pend = 1'b1;
        else if (w && a == 2'd0 && !d[0]) m_pend = 1'b0;
        if (mt) m_tog = ~m_tog;
        if (w && a == 2'd0) begin m_sel = d[7:6]; m_en = d[1]; end
        if (w && a == 2'd1) m_ref = d;
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d);
        wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge(w, a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        addr = 2'd2; #0.2; chk(req, rdata, m_cnt);
        addr = 2'd0; #0.2; chk(req, rdata, ctrl_img());
        addr = 2'd1; #0.2; chk(req, rdata, m_ref);
        addr = 2'd3; #0.2; chk("R10", rdata, 8'h00);
        chk("R8", {7'b0, irq_o}, {7'b0, m_pend & m_en});
        chk("R9", {7'b0, match_o}, {7'b0, m_tog});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 2'd0, 8'd0);
            check_all(req);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int r;
        r = $urandom(32'h5EED);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2 R6 R8 R9: fast base, reference 3, enable on, keep pending
        step(1'b1, 2'd1, 8'd3);
        step(1'b1, 2'd0, 8'hCB);
        check_all("R5");
        idle(12, "R2");
        // R7: writing one keeps pending, writing zero clears it
        step(1'b1, 2'd0, 8'hC3); check_all("R7");
        step(1'b1, 2'd0, 8'hC2); check_all("R7");
        step(1'b1, 2'd0, 8'hC1); check_all("R7");
        // R6: disabled interrupt still latches pending
        idle(6, "R6");
        // R5: restart landing on a match suppresses it
        step(1'b1, 2'd1, 8'd5);
        step(1'b1, 2'd0, 8'hCB);
        idle(5, "R5");
        step(1'b1, 2'd0, 8'hCB); check_all("R5");
        step(1'b1, 2'd0, 8'hC3); check_all("R5");
        // R10: count register writes ignored; reference change mid-run
        step(1'b1, 2'd2, 8'hAA); check_all("R10");
        step(1'b1, 2'd3, 8'h55); check_all("R10");
        idle(2, "R10");
        step(1'b1, 2'd1, 8'd1); check_all("R10");
        idle(8, "R10");
        // R3: divided base, reference 1
        step(1'b1, 2'd0, 8'h0B);
        idle(800, "R3");
        // R4: hold codes
        step(1'b1, 2'd0, 8'h43); idle(20, "R4");
        step(1'b1, 2'd0, 8'h83); idle(20, "R4");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            r = $urandom % 100;
            if (r < 4) begin
                logic [7:0] d;
                d = $urandom;
                d[7:6] = ($urandom % 3 == 0) ? d[7:6] : 2'b11;
                step(1'b1, 2'd0, d);
            end else if (r < 7) step(1'b1, 2'd1, 8'($urandom % 8));
            else if (r < 8)     step(1'b1, 2'($urandom % 4) | 2'd2, 8'($urandom));
            else                step(1'b0, 2'd0, 8'd0);
            check_all("R2");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule